// File: doc/BRIEF.md
# Quad-SPI nibble transmit master

This block is a four-lane SPI master data path. It takes bytes from a valid/ready input stream and shifts each one out over four IO lanes in exactly two SCK periods. The high nibble goes first, then the low nibble, and each lane carries one bit of the nibble. It drives the active-low select low around a burst of bytes and produces SCK from the system clock through a programmable divider. SCK polarity and sampling phase can be chosen.

When the read direction is chosen, all four lane drivers are released. Each accepted input item then starts one byte slot, and its data value is ignored. The lanes are sampled on the sampling edges, and the byte is assembled in the same nibble order. Each assembled byte is returned on a one-cycle output strobe.

A burst continues for as long as a new byte is offered at each byte boundary. The bytes follow each other with no idle SCK time. Polarity, phase, direction and divider are taken when a burst starts, and they hold until the burst ends.

Top module: `qspi_nib_master`

## Requirements
- R1: In write direction, the first SCK period of a byte drives bit 4+k of the byte on lane k (k = 0..3). The second period drives bit k on lane k. Frames are always 8 bits.
- R2: Every byte occupies exactly two SCK periods, which is four SCK edges. A burst of n bytes produces 4n edges.
- R3: While select is high, SCK follows the polarity input one cycle later: 0 means SCK idles low and 1 means it idles high.
- R4: With phase 0, lanes are sampled on the first edge of each SCK period and change on the second edge. With phase 1, they are sampled on the second edge and change on the first edge.
- R5: Bytes of a burst follow back to back. Every SCK edge of a burst is spaced one half period from the previous one, and select stays low throughout.
- R6: One SCK half period lasts max(1, half_div_i) system clock cycles, so the smallest division is 2.
- R7: The first SCK edge comes exactly one half period after select falls. Select rises exactly one half period after the last edge.
- R8: A burst ends when no valid byte is offered at a byte boundary. tx_ready_o is high whenever select is high. A later valid byte starts a new burst.
- R9: In read direction, io_oe_o is 0 on all lanes. The sampled lanes are assembled as {first nibble, second nibble}, and rx_valid_o pulses for one cycle for each byte, only in read direction.
- R10: In write direction, io_oe_o is all ones while select is low. io_oe_o is all zeros whenever select is high.
- R11: Polarity, phase, direction and divider inputs are sampled at the start of a burst. Changes to them during the burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: sample on first edge, 1: sample on second edge |
| rd_mode_i | input | 1 | 1: read direction, 0: write direction |
| half_div_i | input | DIV_W | System cycles per SCK half period (0 acts as 1) |
| tx_data_i | input | 2*LANES | Byte to transmit |
| tx_valid_i | input | 1 | Input byte valid |
| tx_ready_o | output | 1 | Input byte accepted when high with valid |
| rx_data_o | output | 2*LANES | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low select |
| io_o | output | LANES | Lane output values |
| io_oe_o | output | LANES | Lane output enables |
| io_i | input | LANES | Lane input values |

## Verification
The hardest case to reach is a change of configuration inputs while a burst is in flight. A second hard case is a byte handed over on the exact cycle of the fourth edge, at the minimum division. The stimulus keeps valid asserted across byte boundaries, so the handover lands on the last edge of each byte. In one scenario it flips polarity, phase, direction and divider right after the first byte is accepted. The bench then measures edge spacing and decodes lane data against the settings in force at the start. A gap scenario drops valid for several half periods at a boundary, which forces the burst to close and reopen.

// File: rtl/qspi_nib_pkg.sv
`timescale 1ns/1ps
package qspi_nib_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2
  } qspi_st_e;

  localparam int unsigned EDGES_PER_BYTE = 4;
endpackage

// File: rtl/qspi_nib_clkdiv.sv
`timescale 1ns/1ps
module qspi_nib_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero acts as one: smallest division is 2
  assign lim    = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qspi_nib_lane_tx.sv
`timescale 1ns/1ps
module qspi_nib_lane_tx #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [LANES-1:0] nib_i,
  input  logic             oe_en_i,
  output logic [LANES-1:0] io_o,
  output logic [LANES-1:0] io_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bit_q <= 1'b0;
      else if (ld_i) bit_q <= nib_i[g];
    end
    assign io_o[g]    = bit_q;
    assign io_oe_o[g] = oe_en_i;
  end
endmodule

// File: rtl/qspi_nib_lane_rx.sv
`timescale 1ns/1ps
module qspi_nib_lane_rx #(
  parameter int unsigned LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_i,
  input  logic               hi_i,
  input  logic [LANES-1:0]   io_i,
  output logic [2*LANES-1:0] data_o,
  output logic               valid_o
);
  logic [LANES-1:0]   hi_q;
  logic [2*LANES-1:0] data_q;
  logic               valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= smp_i && !hi_i;
      if (smp_i && hi_i)  hi_q   <= io_i;
      if (smp_i && !hi_i) data_q <= {hi_q, io_i};
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/qspi_nib_master.sv
`timescale 1ns/1ps
module qspi_nib_master
  import qspi_nib_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DIV_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               rd_mode_i,
  input  logic [DIV_W-1:0]   half_div_i,
  input  logic [2*LANES-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [2*LANES-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               sck_o,
  output logic               cs_no,
  output logic [LANES-1:0]   io_o,
  output logic [LANES-1:0]   io_oe_o,
  input  logic [LANES-1:0]   io_i
);
  localparam int unsigned BYTE_W = 2 * LANES;
  localparam int unsigned EW     = $clog2(EDGES_PER_BYTE);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES_PER_BYTE - 1);

  qspi_st_e          st_q, st_d;
  logic [EW-1:0]     h_q, h_d;
  logic [BYTE_W-1:0] byte_q;
  logic              cpha_q, dir_q, sck_q;
  logic [DIV_W-1:0]  half_q;
  logic              tick, edge_w, last_edge, accept, start;
  logic              cpha_now, ld;
  logic [LANES-1:0]  nib;
  logic              smp, smp_hi;

  qspi_nib_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .half_i (half_q),
    .tick_o (tick)
  );

  assign start      = (st_q == ST_IDLE) && tx_valid_i;
  assign edge_w     = (st_q == ST_XFER) && tick;
  assign last_edge  = edge_w && (h_q == LAST_EDGE);
  assign tx_ready_o = (st_q == ST_IDLE) || last_edge;
  assign accept     = tx_ready_o && tx_valid_i;

  always_comb begin
    st_d = st_q;
    h_d  = h_q;
    unique case (st_q)
      ST_IDLE: if (tx_valid_i) begin
        st_d = ST_XFER;
        h_d  = '0;
      end
      ST_XFER: if (edge_w) begin
        h_d = h_q + 1'b1;
        if (h_q == LAST_EDGE && !tx_valid_i) st_d = ST_TRAIL;
      end
      ST_TRAIL: if (tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      h_q    <= '0;
      byte_q <= '0;
      cpha_q <= 1'b0;
      dir_q  <= 1'b0;
      half_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      h_q  <= h_d;
      if (accept) byte_q <= tx_data_i;
      if (start) begin
        cpha_q <= cpha_i;
        dir_q  <= rd_mode_i;
        half_q <= half_div_i;
      end
      if (st_q == ST_IDLE) sck_q <= cpol_i;
      else if (edge_w)     sck_q <= ~sck_q;
    end
  end

  // launch: phase 0 drives ahead of the first edge, phase 1 on leading edges
  assign cpha_now = (st_q == ST_IDLE) ? cpha_i : cpha_q;

  always_comb begin
    ld  = 1'b0;
    nib = byte_q[BYTE_W-1:LANES];
    if (accept && !cpha_now) begin
      ld  = 1'b1;
      nib = tx_data_i[BYTE_W-1:LANES];
    end else if (edge_w) begin
      if (cpha_q) begin
        if (h_q == EW'(0)) begin
          ld = 1'b1;
          nib = byte_q[BYTE_W-1:LANES];
        end else if (h_q == EW'(2)) begin
          ld = 1'b1;
          nib = byte_q[LANES-1:0];
        end
      end else if (h_q == EW'(1)) begin
        ld  = 1'b1;
        nib = byte_q[LANES-1:0];
      end
    end
  end

  assign smp    = edge_w && (h_q[0] == cpha_q);
  assign smp_hi = !h_q[EW-1];

  qspi_nib_lane_tx #(.LANES(LANES)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld),
    .nib_i   (nib),
    .oe_en_i ((st_q != ST_IDLE) && !dir_q),
    .io_o    (io_o),
    .io_oe_o (io_oe_o)
  );

  qspi_nib_lane_rx #(.LANES(LANES)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (smp && dir_q),
    .hi_i    (smp_hi),
    .io_i    (io_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

  assign cs_no = (st_q == ST_IDLE);
  assign sck_o = sck_q;
endmodule

// File: rtl/qspi_nib_master_chk.sv
`timescale 1ns/1ps
module qspi_nib_master_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_no,
  input logic             sck_o,
  input logic             cpol_i,
  input logic [LANES-1:0] io_oe_o,
  input logic             rx_valid_o,
  input logic             tx_ready_o,
  input logic             dir_q
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && cs_no && $past(cs_no) |-> sck_o == $past(cpol_i));

  assert_oe_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no && dir_q |-> io_oe_o == '0);

  assert_rx_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_dir_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> dir_q);

  assert_oe_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> io_oe_o == '0);

  assert_ready_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> tx_ready_o);
endmodule

bind qspi_nib_master qspi_nib_master_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_no      (cs_no),
  .sck_o      (sck_o),
  .cpol_i     (cpol_i),
  .io_oe_o    (io_oe_o),
  .rx_valid_o (rx_valid_o),
  .tx_ready_o (tx_ready_o),
  .dir_q      (dir_q)
);

// File: tb/qspi_nib_master_test.sv
`timescale 1ns/1ps
module qspi_nib_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, rd_mode = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, sck, cs_n;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'd0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qspi_nib_master uut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .rd_mode_i(rd_mode),
    .half_div_i(half_div), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sck_o(sck), .cs_no(cs_n),
    .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in)
  );

  // expected settings of the burst in flight
  bit e_cpha = 0, e_dir = 0;
  int e_half = 2;

  logic [7:0] txb [0:16];
  logic [7:0] rdb [0:16];
  logic [7:0] cap [0:16];
  logic [7:0] rxb [0:16];
  logic [3:0] cap_hi;
  int cap_n, rx_n, tot_edges, cs_falls, bad_int, oe_bad, idle_bad;
  int cyc = 0, t_fall, t_last, lead, trail;
  bit first_edge;
  logic prev_cs = 1'b1, prev_sck = 1'b0, prev_cpol = 1'b0;

  task automatic clear_stats();
    cap_n = 0; rx_n = 0; tot_edges = 0; cs_falls = 0;
    bad_int = 0; oe_bad = 0; idle_bad = 0; lead = -1; trail = -1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model and bus monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        cs_falls++;
        t_fall = cyc;
        first_edge = 1'b1;
        if (e_dir && !e_cpha) io_in = rdb[tot_edges / 4][7:4];
      end
      if (!cs_n && sck != prev_sck) begin
        int k, bi;
        bit smp;
        k = tot_edges % 4;
        bi = tot_edges / 4;
        if (first_edge) begin
          lead = cyc - t_fall;
          first_edge = 1'b0;
        end else if (cyc - t_last != e_half) bad_int++;
        t_last = cyc;
        smp = e_cpha ? (k % 2 == 1) : (k % 2 == 0);
        if (smp && !e_dir) begin
          if (k < 2) cap_hi = io_out;
          else if (bi < 17) begin
            cap[bi] = {cap_hi, io_out};
            cap_n++;
          end
        end
        if (e_dir && bi < 16) begin
          if (!e_cpha && k == 1) io_in = rdb[bi][3:0];
          if (!e_cpha && k == 3) io_in = rdb[bi+1][7:4];
          if (e_cpha && k == 0)  io_in = rdb[bi][7:4];
          if (e_cpha && k == 2)  io_in = rdb[bi][3:0];
        end
        tot_edges++;
      end
      if (!prev_cs && cs_n) trail = cyc - t_last;
      if (cs_n && prev_cs && sck !== prev_cpol) idle_bad++;
      if (cs_n) begin
        if (io_oe !== 4'h0) oe_bad++;
      end else if (io_oe !== (e_dir ? 4'h0 : 4'hf)) oe_bad++;
      if (rx_valid && rx_n < 17) begin
        rxb[rx_n] = rx_data;
        rx_n++;
      end
    end
    prev_cs = cs_n;
    prev_sck = sck;
    prev_cpol = cpol;
  end

  task automatic run_burst(input string name, input int n, input bit pol, input bit pha,
                           input int half, input bit rd, input int gap_after, input bit flip,
                           input int seed);
    int sent;
    @(posedge clk); #1;
    cpol = pol; cpha = pha; half_div = 8'(half); rd_mode = rd;
    e_cpha = pha; e_dir = rd; e_half = (half == 0) ? 1 : half;
    for (int i = 0; i < 17; i++) begin
      txb[i] = 8'((i * 37 + seed) ^ 8'h5c);
      rdb[i] = 8'((i * 29 + seed * 3) ^ 8'ha3);
    end
    repeat (3) @(posedge clk);
    #1;
    clear_stats();
    sent = 0;
    while (sent < n) begin
      tx_valid = 1'b1;
      tx_data = txb[sent];
      @(negedge clk);
      if (tx_ready) begin
        @(posedge clk); #1;
        if (flip && sent == 0) begin
          cpol = ~pol; cpha = ~pha; rd_mode = ~rd; half_div = 8'(half + 2);
        end
        sent++;
        if (gap_after == sent) begin
          tx_valid = 1'b0;
          repeat (10 * e_half + 6) @(posedge clk);
          #1;
        end
      end else begin
        @(posedge clk); #1;
      end
    end
    tx_valid = 1'b0;
    tx_data = 8'hff;
    repeat (6 * e_half + 8) @(posedge clk);
    #1;
    cpol = pol; cpha = pha; rd_mode = rd; half_div = 8'(half);
    repeat (2) @(posedge clk);
    #1;
    chk(cs_n == 1'b1, {name, " R8 select released"}, int'(cs_n), 1);
    chk(cs_falls == ((gap_after > 0) ? 2 : 1), {name, " R8 burst count"}, cs_falls,
        (gap_after > 0) ? 2 : 1);
    chk(tot_edges == 4 * n, {name, " R2 edges per burst"}, tot_edges, 4 * n);
    chk(bad_int == 0, {name, " R5 R6 edge spacing"}, bad_int, 0);
    chk(lead == e_half, {name, " R7 lead"}, lead, e_half);
    chk(trail == e_half, {name, " R7 trail"}, trail, e_half);
    chk(oe_bad == 0, {name, " R10 R9 output enable"}, oe_bad, 0);
    chk(idle_bad == 0, {name, " R3 idle level"}, idle_bad, 0);
    if (!rd) begin
      chk(cap_n == n, {name, " R2 bytes seen"}, cap_n, n);
      for (int i = 0; i < n; i++)
        chk(cap[i] == txb[i], {name, " R1 R4 lane data"}, int'(cap[i]), int'(txb[i]));
    end else begin
      chk(rx_n == n, {name, " R9 rx strobes"}, rx_n, n);
      for (int i = 0; i < n; i++)
        chk(rxb[i] == rdb[i], {name, " R9 R4 rx byte"}, int'(rxb[i]), int'(rdb[i]));
    end
  endtask

  task automatic test_reset();
    #1;
    chk(cs_n == 1'b1, "R8 reset select", int'(cs_n), 1);
    chk(io_oe == 4'h0, "R10 reset enables", int'(io_oe), 0);
    chk(rx_valid == 1'b0, "R9 reset strobe", int'(rx_valid), 0);
    chk(tx_ready == 1'b1, "R8 reset ready", int'(tx_ready), 1);
    chk(sck == 1'b0, "R3 reset sck", int'(sck), 0);
  endtask

  task automatic test_mode0_write();  run_burst("mode0", 4, 0, 0, 2, 0, 0, 0, 1);  endtask
  task automatic test_mode3_write();  run_burst("mode3", 5, 1, 1, 3, 0, 0, 0, 7);  endtask
  task automatic test_mode1_write();  run_burst("mode1", 3, 0, 1, 2, 0, 0, 0, 11); endtask
  task automatic test_mode2_write();  run_burst("mode2", 3, 1, 0, 4, 0, 0, 0, 19); endtask
  task automatic test_min_div();
    run_burst("div0 R6", 6, 0, 0, 0, 0, 0, 0, 23);
    run_burst("div1 R6", 4, 1, 1, 1, 0, 0, 0, 31);
  endtask
  task automatic test_gap();          run_burst("gap R8", 6, 0, 1, 2, 0, 3, 0, 41); endtask
  task automatic test_read();
    run_burst("read0 R9", 5, 0, 0, 2, 1, 0, 0, 53);
    run_burst("read3 R9", 4, 1, 1, 1, 1, 0, 0, 59);
  endtask
  task automatic test_cfg_hold();
    run_burst("hold_w R11", 5, 0, 0, 3, 0, 0, 1, 67);
    run_burst("hold_r R11", 4, 1, 1, 2, 1, 0, 1, 71);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    test_reset();
    test_mode0_write();
    test_mode3_write();
    test_mode1_write();
    test_mode2_write();
    test_min_div();
    test_gap();
    test_read();
    test_cfg_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule